// File: doc/BRIEF.md
# Page-Table DMA Address Translator

This block maps bus addresses issued by DMA masters onto physical addresses. It keeps a single-level table of 64-bit translation entries in on-chip registers. Each entry holds a physical page address in its upper bits and a 2-bit access code in its two lowest bits. A translate port takes an address and a read/write flag. One cycle later it answers with the page-aligned input address, the physical page address, the mask of the in-page offset, the access code, and a flag that says whether the requested direction is permitted.

A second port reads or writes one table entry per operation, so that control logic can load the table and inspect it. Before indexing, this port aligns the bus address to the page and subtracts a programmable base offset. Every write it accepts is echoed on a one-cycle update strobe so that downstream translation caches can drop stale copies. A configuration strobe loads three settings: the page shift, which is clamped to a supported range; the base offset; and a bypass mode in which every address gets full access without a table lookup.

Top module: `dma_xlate_table`

## Requirements
- R1: The access code is the two lowest entry bits: 0 = fault (no access), 1 = read only, 2 = write only, 3 = read and write. rsp_allow_o is bit 0 of the code for a read and bit 1 for a write.
- R2: In bypass mode every translation returns code 3, allow 1, an all-ones mask, and zero for both the aligned address and the physical address, whatever the table holds.
- R3: The translation index is req_addr_i shifted right by the page shift, with no base subtracted. An index at or above NUM_ENTRIES returns code 0, allow 0, an all-ones mask and zero addresses.
- R4: For an in-range index, with page mask PM = ~((1<<shift)-1): rsp_iova_o = addr & PM, rsp_paddr_o = entry & PM, rsp_mask_o = ~PM.
- R5: An entry operation uses index ((ent_addr_i & PM) - base) >> shift. A write stores ent_wdata_i in full. A read returns the stored word on ent_rdata_o in the cycle after the request, together with ent_done_o.
- R6: An entry operation whose index is at or above NUM_ENTRIES sets ent_err_o with ent_done_o, leaves the table unchanged and returns ent_rdata_o = 0. A base larger than the aligned address wraps and also fails.
- R7: Reset clears every entry to zero, clears bypass, sets the shift to MIN_SHIFT and the base to zero, and drops all valid outputs.
- R8: A translate request is accepted when req_valid_i and req_ready_o are both high, and req_ready_o = !rsp_valid_o || rsp_ready_i. The response is valid in the next cycle and holds steady while rsp_ready_i is low.
- R9: A configured page shift below MIN_SHIFT (12) is raised to MIN_SHIFT. One above MAX_SHIFT (24) is lowered to MAX_SHIFT.
- R10: An accepted entry write raises upd_valid_o for one cycle, together with ent_done_o. The strobe carries upd_iova_o = ent_addr_i & PM, upd_paddr_o = ent_wdata_i & PM and upd_perm_o = ent_wdata_i[1:0]. Reads and rejected writes raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load the configuration settings |
| cfg_bypass_i | input | 1 | Bypass mode value |
| cfg_shift_i | input | SHIFT_W | Requested page shift (clamped) |
| cfg_base_i | input | ADDR_W | Base offset for entry operations |
| req_valid_i | input | 1 | Translate request valid |
| req_ready_o | output | 1 | Translate request accepted |
| req_addr_i | input | ADDR_W | Address to translate |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| rsp_valid_o | output | 1 | Translate response valid |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_iova_o | output | ADDR_W | Page-aligned input address |
| rsp_paddr_o | output | ADDR_W | Translated page address |
| rsp_mask_o | output | ADDR_W | In-page offset mask |
| rsp_perm_o | output | 2 | Access code |
| rsp_allow_o | output | 1 | Requested direction permitted |
| ent_valid_i | input | 1 | Entry operation request |
| ent_write_i | input | 1 | 1 = write entry, 0 = read entry |
| ent_addr_i | input | ADDR_W | Bus address selecting the entry |
| ent_wdata_i | input | ADDR_W | Entry word to store |
| ent_done_o | output | 1 | Entry operation finished |
| ent_err_o | output | 1 | Entry operation rejected (index out of range) |
| ent_rdata_o | output | ADDR_W | Entry word read |
| upd_valid_o | output | 1 | Table update strobe |
| upd_iova_o | output | ADDR_W | Page-aligned bus address of the update |
| upd_paddr_o | output | ADDR_W | Page-aligned physical address of the update |
| upd_perm_o | output | 2 | Access code of the update |

## Verification
Translations are tried against entries holding each of the four access codes, in both directions, so that an error in decoding the code shows up as a wrong allow flag. Lookups at the last valid index and one past it tell the range compare apart from an off-by-one. Entry addresses that carry a nonzero base and in-page offset bits show whether the base is subtracted and whether the address is aligned first, and translations at the same table index show that no base is applied there. Shift settings below, inside and above the range, bypass on and off, a stalled response, and a second reset separate the clamp, the bypass path, the hold of the output register and the clearing of the table.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

   typedef enum logic [1:0] {
      PERM_FAULT = 2'd0,
      PERM_RONLY = 2'd1,
      PERM_WONLY = 2'd2,
      PERM_RDWR  = 2'd3
   } dxl_perm_e;

   // Direction check: bit 0 grants reads, bit 1 grants writes.
   function automatic logic dir_allowed(input dxl_perm_e p, input logic wr);
      logic [1:0] pv;
      pv = p;
      return wr ? pv[1] : pv[0];
   endfunction

   function automatic int clamp_shift(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

endpackage

// File: rtl/dxl_mask_gen.sv
module dxl_mask_gen #(
   parameter int ADDR_W    = 64,
   parameter int SHIFT_W   = 6,
   parameter int MIN_SHIFT = 12,
   parameter int MAX_SHIFT = 24
) (
   input  logic [SHIFT_W-1:0] shift_i,
   output logic [ADDR_W-1:0]  page_mask_o
);

   // Bits below the minimum shift are always offset bits, bits at or above
   // the maximum shift are always page bits; only the band in between
   // depends on the runtime shift.
   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      if (b < MIN_SHIFT) begin : g_low
         assign page_mask_o[b] = 1'b0;
      end else if (b >= MAX_SHIFT) begin : g_high
         assign page_mask_o[b] = 1'b1;
      end else begin : g_var
         assign page_mask_o[b] = (b >= int'(shift_i));
      end
   end

endmodule

// File: rtl/dxl_range_idx.sv
module dxl_range_idx #(
   parameter int ADDR_W      = 64,
   parameter int SHIFT_W     = 6,
   parameter int NUM_ENTRIES = 256,
   parameter int IDX_W       = 8
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [SHIFT_W-1:0] shift_i,
   output logic [IDX_W-1:0]   idx_o,
   output logic               in_range_o
);

   logic [ADDR_W-1:0] full_idx;

   assign full_idx   = addr_i >> shift_i;
   assign in_range_o = full_idx < ADDR_W'(NUM_ENTRIES);
   assign idx_o      = full_idx[IDX_W-1:0];

endmodule

// File: rtl/dxl_entry_table.sv
module dxl_entry_table #(
   parameter int ADDR_W      = 64,
   parameter int NUM_ENTRIES = 256,
   parameter int IDX_W       = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [ADDR_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  ridx_a_i,
   output logic [ADDR_W-1:0] rdata_a_o,
   input  logic [IDX_W-1:0]  ridx_b_i,
   output logic [ADDR_W-1:0] rdata_b_o
);

   logic [ADDR_W-1:0] rows [NUM_ENTRIES];

   for (genvar r = 0; r < NUM_ENTRIES; r++) begin : g_row
      logic [ADDR_W-1:0] row_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            row_q <= '0;
         end else if (we_i && (widx_i == IDX_W'(r))) begin
            row_q <= wdata_i;
         end
      end
      assign rows[r] = row_q;
   end

   always_comb begin
      rdata_a_o = '0;
      rdata_b_o = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (ridx_a_i == IDX_W'(i)) rdata_a_o = rows[i];
         if (ridx_b_i == IDX_W'(i)) rdata_b_o = rows[i];
      end
   end

endmodule

// File: rtl/dma_xlate_table.sv
module dma_xlate_table #(
   parameter int ADDR_W      = 64,
   parameter int NUM_ENTRIES = 256,
   parameter int MIN_SHIFT   = 12,
   parameter int MAX_SHIFT   = 24,
   parameter int SHIFT_W     = $clog2(ADDR_W)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cfg_we_i,
   input  logic               cfg_bypass_i,
   input  logic [SHIFT_W-1:0] cfg_shift_i,
   input  logic [ADDR_W-1:0]  cfg_base_i,
   input  logic               req_valid_i,
   output logic               req_ready_o,
   input  logic [ADDR_W-1:0]  req_addr_i,
   input  logic               req_write_i,
   output logic               rsp_valid_o,
   input  logic               rsp_ready_i,
   output logic [ADDR_W-1:0]  rsp_iova_o,
   output logic [ADDR_W-1:0]  rsp_paddr_o,
   output logic [ADDR_W-1:0]  rsp_mask_o,
   output logic [1:0]         rsp_perm_o,
   output logic               rsp_allow_o,
   input  logic               ent_valid_i,
   input  logic               ent_write_i,
   input  logic [ADDR_W-1:0]  ent_addr_i,
   input  logic [ADDR_W-1:0]  ent_wdata_i,
   output logic               ent_done_o,
   output logic               ent_err_o,
   output logic [ADDR_W-1:0]  ent_rdata_o,
   output logic               upd_valid_o,
   output logic [ADDR_W-1:0]  upd_iova_o,
   output logic [ADDR_W-1:0]  upd_paddr_o,
   output logic [1:0]         upd_perm_o
);
   import dxl_pkg::*;

   localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

   // Elaboration-time parameter checks
   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 1024) begin : g_bad_num
      $error("dma_xlate_table: NUM_ENTRIES must be 1..1024");
   end
   if (MIN_SHIFT < 1 || MIN_SHIFT > MAX_SHIFT) begin : g_bad_shift
      $error("dma_xlate_table: need 1 <= MIN_SHIFT <= MAX_SHIFT");
   end
   if (MAX_SHIFT >= ADDR_W || MAX_SHIFT >= (1 << SHIFT_W)) begin : g_bad_width
      $error("dma_xlate_table: MAX_SHIFT does not fit ADDR_W/SHIFT_W");
   end

   // ---------------- configuration state ----------------
   logic               bypass_q;
   logic [SHIFT_W-1:0] shift_q;
   logic [ADDR_W-1:0]  base_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bypass_q <= 1'b0;
         shift_q  <= SHIFT_W'(MIN_SHIFT);
         base_q   <= '0;
      end else if (cfg_we_i) begin
         bypass_q <= cfg_bypass_i;
         shift_q  <= SHIFT_W'(clamp_shift(int'(cfg_shift_i), MIN_SHIFT, MAX_SHIFT));
         base_q   <= cfg_base_i;
      end
   end

   logic [ADDR_W-1:0] page_mask;

   dxl_mask_gen #(
      .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W),
      .MIN_SHIFT(MIN_SHIFT), .MAX_SHIFT(MAX_SHIFT)
   ) u_mask (
      .shift_i     (shift_q),
      .page_mask_o (page_mask)
   );

   // ---------------- index computation ----------------
   logic [IDX_W-1:0]  x_idx, e_idx;
   logic              x_in, e_in;
   logic [ADDR_W-1:0] e_aligned, e_rel;
   logic [ADDR_W-1:0] x_entry, e_entry;

   assign e_aligned = ent_addr_i & page_mask;
   assign e_rel     = e_aligned - base_q;

   dxl_range_idx #(
      .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
   ) u_xidx (
      .addr_i(req_addr_i), .shift_i(shift_q), .idx_o(x_idx), .in_range_o(x_in)
   );

   dxl_range_idx #(
      .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
   ) u_eidx (
      .addr_i(e_rel), .shift_i(shift_q), .idx_o(e_idx), .in_range_o(e_in)
   );

   logic tbl_we;
   assign tbl_we = ent_valid_i && ent_write_i && e_in;

   dxl_entry_table #(
      .ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
   ) u_table (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (tbl_we),
      .widx_i    (e_idx),
      .wdata_i   (ent_wdata_i),
      .ridx_a_i  (x_idx),
      .rdata_a_o (x_entry),
      .ridx_b_i  (e_idx),
      .rdata_b_o (e_entry)
   );

   // ---------------- translate path ----------------
   logic [ADDR_W-1:0] n_iova, n_paddr, n_mask;
   dxl_perm_e         n_perm;
   logic              n_allow;

   always_comb begin
      n_iova  = '0;
      n_paddr = '0;
      n_mask  = '1;
      n_perm  = PERM_FAULT;
      if (bypass_q) begin
         n_perm = PERM_RDWR;
      end else if (x_in) begin
         n_iova  = req_addr_i & page_mask;
         n_paddr = x_entry & page_mask;
         n_mask  = ~page_mask;
         n_perm  = dxl_perm_e'(x_entry[1:0]);
      end
      n_allow = dir_allowed(n_perm, req_write_i);
   end

   logic accept;
   assign req_ready_o = !rsp_valid_o || rsp_ready_i;
   assign accept      = req_valid_i && req_ready_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_o <= 1'b0;
         rsp_iova_o  <= '0;
         rsp_paddr_o <= '0;
         rsp_mask_o  <= '0;
         rsp_perm_o  <= 2'd0;
         rsp_allow_o <= 1'b0;
      end else if (accept) begin
         rsp_valid_o <= 1'b1;
         rsp_iova_o  <= n_iova;
         rsp_paddr_o <= n_paddr;
         rsp_mask_o  <= n_mask;
         rsp_perm_o  <= n_perm;
         rsp_allow_o <= n_allow;
      end else if (rsp_ready_i) begin
         rsp_valid_o <= 1'b0;
      end
   end

   // ---------------- entry access path ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ent_done_o  <= 1'b0;
         ent_err_o   <= 1'b0;
         ent_rdata_o <= '0;
         upd_valid_o <= 1'b0;
         upd_iova_o  <= '0;
         upd_paddr_o <= '0;
         upd_perm_o  <= 2'd0;
      end else begin
         ent_done_o  <= ent_valid_i;
         ent_err_o   <= ent_valid_i && !e_in;
         ent_rdata_o <= (ent_valid_i && !ent_write_i && e_in) ? e_entry : '0;
         upd_valid_o <= tbl_we;
         if (tbl_we) begin
            upd_iova_o  <= e_aligned;
            upd_paddr_o <= ent_wdata_i & page_mask;
            upd_perm_o  <= ent_wdata_i[1:0];
         end
      end
   end

endmodule

// File: rtl/dxl_checker.sv
module dxl_checker #(
   parameter int ADDR_W = 64
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bypass_q,
   input logic              req_valid_i,
   input logic              req_ready_o,
   input logic              rsp_valid_o,
   input logic              rsp_ready_i,
   input logic [ADDR_W-1:0] rsp_iova_o,
   input logic [ADDR_W-1:0] rsp_paddr_o,
   input logic [ADDR_W-1:0] rsp_mask_o,
   input logic [1:0]        rsp_perm_o,
   input logic              rsp_allow_o,
   input logic              ent_valid_i,
   input logic              ent_write_i,
   input logic              ent_done_o,
   input logic              ent_err_o,
   input logic              upd_valid_o
);

   a_r8_accept_responds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o) |=> rsp_valid_o);

   a_r8_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && !rsp_ready_i) |=>
         (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_perm_o) && $stable(rsp_mask_o)));

   a_r2_bypass_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o && bypass_q) |=>
         (rsp_perm_o == 2'd3 && (&rsp_mask_o) && rsp_allow_o));

   a_r1_fault_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && rsp_perm_o == 2'd0) |-> !rsp_allow_o);

   a_r4_iova_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> ((rsp_iova_o & rsp_mask_o) == '0));

   a_r5_entry_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_valid_i |=> ent_done_o);

   a_r6_err_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_err_o |-> !upd_valid_o);

   a_r10_upd_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_valid_o |-> (ent_done_o && !ent_err_o));

   a_r10_no_upd_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ent_valid_i && !ent_write_i) |=> !upd_valid_o);

endmodule

bind dma_xlate_table dxl_checker #(.ADDR_W(ADDR_W)) u_dxl_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bypass_q    (bypass_q),
   .req_valid_i (req_valid_i),
   .req_ready_o (req_ready_o),
   .rsp_valid_o (rsp_valid_o),
   .rsp_ready_i (rsp_ready_i),
   .rsp_iova_o  (rsp_iova_o),
   .rsp_paddr_o (rsp_paddr_o),
   .rsp_mask_o  (rsp_mask_o),
   .rsp_perm_o  (rsp_perm_o),
   .rsp_allow_o (rsp_allow_o),
   .ent_valid_i (ent_valid_i),
   .ent_write_i (ent_write_i),
   .ent_done_o  (ent_done_o),
   .ent_err_o   (ent_err_o),
   .upd_valid_o (upd_valid_o)
);

// File: tb/dma_xlate_table_tb_top.sv
`timescale 1ns/1ps
module dma_xlate_table_tb_top;

   localparam int AW   = 64;
   localparam int NUM  = 256;
   localparam int SW   = 6;
   localparam int MINS = 12;
   localparam int MAXS = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0, cfg_bypass = 1'b0;
   logic [SW-1:0] cfg_shift = '0;
   logic [AW-1:0] cfg_base = '0;
   logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
   logic [AW-1:0] req_addr = '0;
   logic          req_ready, rsp_valid, rsp_allow;
   logic [AW-1:0] rsp_iova, rsp_paddr, rsp_mask;
   logic [1:0]    rsp_perm;
   logic          ent_valid = 1'b0, ent_write = 1'b0;
   logic [AW-1:0] ent_addr = '0, ent_wdata = '0;
   logic          ent_done, ent_err, upd_valid;
   logic [AW-1:0] ent_rdata, upd_iova, upd_paddr;
   logic [1:0]    upd_perm;

   always #4 clk = ~clk;   // 125 MHz

   dma_xlate_table #(.ADDR_W(AW), .NUM_ENTRIES(NUM), .MIN_SHIFT(MINS), .MAX_SHIFT(MAXS)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .cfg_we_i(cfg_we), .cfg_bypass_i(cfg_bypass), .cfg_shift_i(cfg_shift), .cfg_base_i(cfg_base),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr), .req_write_i(req_write),
      .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_iova_o(rsp_iova), .rsp_paddr_o(rsp_paddr),
      .rsp_mask_o(rsp_mask), .rsp_perm_o(rsp_perm), .rsp_allow_o(rsp_allow),
      .ent_valid_i(ent_valid), .ent_write_i(ent_write), .ent_addr_i(ent_addr), .ent_wdata_i(ent_wdata),
      .ent_done_o(ent_done), .ent_err_o(ent_err), .ent_rdata_o(ent_rdata),
      .upd_valid_o(upd_valid), .upd_iova_o(upd_iova), .upd_paddr_o(upd_paddr), .upd_perm_o(upd_perm)
   );

   typedef struct {
      logic [AW-1:0] iova, paddr, mask;
      logic [1:0]    perm;
      logic          allow;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   exp_t mon_e;

   // Reference model built from the requirements
   logic [AW-1:0] mdl [NUM];
   int            m_shift = MINS;
   logic [AW-1:0] m_base = '0;
   logic          m_bypass = 1'b0;

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag, input string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s", tag, what);
      end
   endtask

   function automatic logic [AW-1:0] pmask();
      return ~((64'd1 << m_shift) - 64'd1);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NUM; i++) mdl[i] = '0;
      m_shift = MINS; m_base = '0; m_bypass = 1'b0;
   endtask

   // Monitor: samples just before the edge that consumes the response
   always @(negedge clk) begin
      #3;
      if (rst_n && rsp_valid && rsp_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "response with no request outstanding");
         end else begin
            mon_e = exp_q.pop_front();
            chk(rsp_iova == mon_e.iova && rsp_paddr == mon_e.paddr && rsp_mask == mon_e.mask &&
                rsp_perm == mon_e.perm && rsp_allow == mon_e.allow, mon_e.tag,
                $sformatf("iova %h paddr %h mask %h perm %0d allow %0b exp %h %h %h %0d %0b",
                          rsp_iova, rsp_paddr, rsp_mask, rsp_perm, rsp_allow,
                          mon_e.iova, mon_e.paddr, mon_e.mask, mon_e.perm, mon_e.allow));
         end
      end
   end

   function automatic exp_t predict(input logic [AW-1:0] a, input logic wr, input string tag);
      exp_t e;
      logic [AW-1:0] idx, ent;
      e.tag = tag; e.iova = '0; e.paddr = '0; e.mask = '1; e.perm = 2'd0; e.allow = 1'b0;
      idx = a >> m_shift;
      if (m_bypass) begin
         e.perm = 2'd3; e.allow = 1'b1;
      end else if (idx < AW'(NUM)) begin
         ent     = mdl[idx[7:0]];
         e.iova  = a & pmask();
         e.paddr = ent & pmask();
         e.mask  = ~pmask();
         e.perm  = ent[1:0];
         e.allow = wr ? ent[1] : ent[0];
      end
      return e;
   endfunction

   task automatic do_xl(input logic [AW-1:0] a, input logic wr, input string tag);
      exp_q.push_back(predict(a, wr, tag));
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_cfg(input logic byp, input int sh, input logic [AW-1:0] base);
      @(negedge clk);
      cfg_we = 1'b1; cfg_bypass = byp; cfg_shift = SW'(sh); cfg_base = base;
      @(negedge clk);
      cfg_we = 1'b0;
      m_bypass = byp;
      m_shift = (sh < MINS) ? MINS : ((sh > MAXS) ? MAXS : sh);
      m_base = base;
   endtask

   task automatic do_ent(input logic wr, input logic [AW-1:0] a, input logic [AW-1:0] d,
                         input string tag);
      logic [AW-1:0] al, idx, exp_rd;
      logic          err;
      al  = a & pmask();
      idx = (al - m_base) >> m_shift;
      err = !(idx < AW'(NUM));
      exp_rd = (wr || err) ? '0 : mdl[idx[7:0]];
      @(negedge clk);
      ent_valid = 1'b1; ent_write = wr; ent_addr = a; ent_wdata = d;
      @(negedge clk);
      ent_valid = 1'b0;
      chk(ent_done && ent_err == err, tag,
          $sformatf("done %0b err %0b exp done 1 err %0b", ent_done, ent_err, err));
      if (!wr)
         chk(ent_rdata == exp_rd, tag, $sformatf("rdata %h exp %h", ent_rdata, exp_rd));
      if (wr && !err) begin
         chk(upd_valid && upd_iova == al && upd_paddr == (d & pmask()) && upd_perm == d[1:0], "R10",
             $sformatf("upd %0b %h %h %0d exp 1 %h %h %0d", upd_valid, upd_iova, upd_paddr,
                       upd_perm, al, d & pmask(), d[1:0]));
         mdl[idx[7:0]] = d;
      end else begin
         chk(!upd_valid, "R10", $sformatf("upd_valid %0b exp 0", upd_valid));
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      model_reset();
      chk(!rsp_valid && !ent_done && !upd_valid && req_ready, "R7",
          $sformatf("rsp_valid %0b ent_done %0b upd %0b ready %0b exp 0 0 0 1",
                    rsp_valid, ent_done, upd_valid, req_ready));
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      repeat (10) begin
         if (exp_q.size() != 0) @(negedge clk);
      end
      if (exp_q.size() != 0)
         chk(1'b0, "R8", $sformatf("%0d responses missing, exp 0", exp_q.size()));
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   localparam logic [AW-1:0] BASE = 64'h1_0000;

   initial begin
      model_reset();
      do_reset();
      // R7: cleared table seen through both ports
      do_xl(64'h0000_3055, 1'b0, "R7");
      do_ent(1'b0, 64'h0000_5000, '0, "R7");

      do_cfg(1'b0, 12, BASE);
      // R5 / R10: base subtracted, offset bits dropped
      do_ent(1'b1, BASE + 64'h3123, 64'h0000_00AB_CDEF_0001, "R5");
      do_ent(1'b0, BASE + 64'h3FFF, '0, "R5");
      do_ent(1'b1, BASE + 64'h4000, 64'h0000_0012_3456_7FF2, "R5");
      do_ent(1'b1, BASE + 64'h5000, 64'h0000_0077_8899_A003, "R5");
      do_ent(1'b1, BASE + 64'h6000, 64'h0000_0011_2233_4000, "R5");
      // R1 / R4: each access code, both directions, no base on translate
      do_xl(64'h0000_307A, 1'b0, "R4");
      do_xl(64'h0000_307A, 1'b1, "R1");
      do_xl(64'h0000_4ABC, 1'b0, "R1");
      do_xl(64'h0000_4ABC, 1'b1, "R1");
      do_xl(64'h0000_5001, 1'b0, "R1");
      do_xl(64'h0000_5001, 1'b1, "R1");
      do_xl(64'h0000_6FFF, 1'b1, "R1");
      // R3: last entry vs one past the end
      do_ent(1'b1, BASE + 64'h000F_F000, 64'h0000_0099_0000_0F03, "R3");
      do_xl(64'h000F_F010, 1'b0, "R3");
      do_xl(64'h0010_0000, 1'b0, "R3");
      do_xl(64'hFFFF_0000_0000_0000, 1'b1, "R3");
      // R6: rejected entry operations leave the table alone
      do_ent(1'b1, BASE + 64'h0010_0000, 64'hDEAD_BEEF_0000_0003, "R6");
      do_ent(1'b1, BASE - 64'h1000, 64'hDEAD_BEEF_0000_0003, "R6");
      do_ent(1'b0, BASE + 64'h0010_0000, '0, "R6");
      do_ent(1'b0, BASE + 64'h000F_F000, '0, "R6");
      do_ent(1'b0, 64'h0000_0000, '0, "R6");
      // R2: bypass ignores the table
      do_cfg(1'b1, 12, BASE);
      do_xl(64'h0000_6123, 1'b1, "R2");
      do_xl(64'h0123_4567_89AB_CDEF, 1'b0, "R2");
      // R9: shift clamp
      do_cfg(1'b0, 40, 64'h0);
      do_ent(1'b1, 64'h0300_0000, 64'h0000_00AA_5500_0003, "R9");
      do_xl(64'h0312_3456, 1'b0, "R9");
      do_cfg(1'b0, 3, BASE);
      do_xl(64'h0000_3999, 1'b0, "R9");
      do_cfg(1'b0, 16, BASE);
      do_xl(64'h0005_ABCD, 1'b1, "R4");
      do_cfg(1'b0, 12, BASE);

      // R8: stalled response holds, ready follows
      @(negedge clk);
      rsp_ready = 1'b0;
      exp_q.push_back(predict(64'h0000_3ABC, 1'b0, "R8"));
      req_valid = 1'b1; req_addr = 64'h0000_3ABC; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid && !req_ready, "R8",
          $sformatf("valid %0b ready %0b exp 1 0", rsp_valid, req_ready));
      begin
         logic [AW-1:0] held;
         held = rsp_paddr;
         @(negedge clk);
         chk(rsp_valid && rsp_paddr == held, "R8",
             $sformatf("valid %0b paddr %h exp 1 %h", rsp_valid, rsp_paddr, held));
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R8",
          $sformatf("valid %0b ready %0b exp 0 1", rsp_valid, req_ready));

      // R7: second reset clears table and bypass
      do_cfg(1'b1, 12, BASE);
      do_reset();
      do_ent(1'b0, 64'h0000_3000, '0, "R7");
      do_xl(64'h0000_3000, 1'b0, "R7");
      do_xl(64'h0100_0000, 1'b0, "R7");

      finish_run();
   end

endmodule